// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter clocked by the functional clock. Software programs a period count and a compare count through a small memory-mapped register port. The counter runs from zero up to the period count and then returns to zero, so one waveform period lasts period+1 clocks. The compare count sets how many clocks of each period the output spends at its active level. A polarity bit chooses whether the active level is high or low.

Each of the two counts can be written in two ways. A write to the live register takes effect on the next clock, which suits a stopped channel. A write to the staging register only marks a pending update. The block copies a pending value into the live register when the counter wraps, so the period in progress always finishes with the values it started with. A control register holds the output-enable, polarity, counter-run and sync-select fields. An external sync pulse clears the counter unless the sync-select field blocks it.

Top module: `shadow_pwm`

## Requirements
- R1: After reset, every register reads zero, both pending flags are clear, the counter is stopped and `pwm_out` is low.
- R2: A write to the live period register (byte offset 0x08) or the live compare register (offset 0x0C) is visible on read-back and in the waveform from the next clock.
- R3: While control bit 4 is set, the counter counts up from 0 to the live period P and then returns to 0, so one output period lasts P+1 clocks. While bit 4 is clear, the counter holds its value and `pwm_out` does not change.
- R4: With control bit 9 set and bit 10 clear, `pwm_out` is high for C clocks of each period, where C is the live compare value and 0 < C < P.
- R5: With control bits 9 and 10 both set, `pwm_out` is low for C clocks of each period and high for the remaining P+1-C clocks.
- R6: While control bit 9 is clear, `pwm_out` is held low, whatever the counter, compare value and polarity are.
- R7: A compare value of zero keeps the output at its inactive level for the whole period. A compare value greater than or equal to P keeps it at its active level for the whole period.
- R8: A write to the staging period register (offset 0x10) or the staging compare register (offset 0x14) sets `shadow_pending` bit 0 or bit 1 respectively, and leaves the live value unchanged. When the running counter wraps, each pending value is copied into its live register and both flags clear.
- R9: A pulse on `sync_evt` clears the counter to zero on the next clock when control bits 7:6 are anything other than 11. When they are 11, the pulse has no effect.
- R10: The control register sits at offset 0x2A. Only bits 10, 9, 7, 6 and 4 are stored, and all its other bits read as zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register to access |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| sync_evt | input | 1 | External counter-clear pulse |
| shadow_pending | output | 2 | Pending update flags: bit 0 is period, bit 1 is compare |
| pwm_out | output | 1 | PWM waveform, registered |

## Verification
The bench uses the default parameters: a 32-bit counter and a 6-bit byte address. Periods stay at 15 or below, so a full period, a shadow transfer and several wraps all complete within a few dozen clocks. This keeps both compare extremes in view: zero, and values equal to or above the period. The full counter width is still present, so the read path and the wrap comparison are exercised at their real width.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;

    // Byte offsets seen by software
    localparam logic [7:0] OFS_PER_LIVE  = 8'h08;
    localparam logic [7:0] OFS_CMP_LIVE  = 8'h0C;
    localparam logic [7:0] OFS_PER_STAGE = 8'h10;
    localparam logic [7:0] OFS_CMP_STAGE = 8'h14;
    localparam logic [7:0] OFS_CTRL      = 8'h2A;

    // Control field positions
    localparam int BIT_RUN  = 4;
    localparam int BIT_SYNC = 6;
    localparam int BIT_EN   = 9;
    localparam int BIT_INV  = 10;

    localparam logic [1:0] SYNC_BLOCKED = 2'b11;

    typedef struct packed {
        logic       inv;
        logic       en;
        logic [1:0] sync_sel;
        logic       run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
        ctrl_t c;
        c.inv      = w[BIT_INV];
        c.en       = w[BIT_EN];
        c.sync_sel = w[BIT_SYNC+1:BIT_SYNC];
        c.run      = w[BIT_RUN];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_to_word(input ctrl_t c);
        logic [15:0] w;
        w = '0;
        w[BIT_INV]               = c.inv;
        w[BIT_EN]                = c.en;
        w[BIT_SYNC+1:BIT_SYNC]   = c.sync_sel;
        w[BIT_RUN]               = c.run;
        return w;
    endfunction

endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
    import shadow_pwm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              wrap,
    output logic [CNT_W-1:0]  per_live,
    output logic [CNT_W-1:0]  cmp_live,
    output ctrl_t             ctrl,
    output logic [1:0]        pending
);

    localparam logic [ADDR_W-1:0] A_PER_L = ADDR_W'(OFS_PER_LIVE);
    localparam logic [ADDR_W-1:0] A_CMP_L = ADDR_W'(OFS_CMP_LIVE);
    localparam logic [ADDR_W-1:0] A_PER_S = ADDR_W'(OFS_PER_STAGE);
    localparam logic [ADDR_W-1:0] A_CMP_S = ADDR_W'(OFS_CMP_STAGE);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

    logic [CNT_W-1:0] per_stage;
    logic [CNT_W-1:0] cmp_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_live  <= '0;
            cmp_live  <= '0;
            per_stage <= '0;
            cmp_stage <= '0;
            ctrl      <= '0;
            pending   <= '0;
        end else begin
            // Boundary transfer first; a same-cycle bus write overrides it.
            if (wrap) begin
                if (pending[0]) per_live <= per_stage;
                if (pending[1]) cmp_live <= cmp_stage;
                pending <= '0;
            end
            if (wr) begin
                case (addr)
                    A_PER_L: per_live <= wdata;
                    A_CMP_L: cmp_live <= wdata;
                    A_PER_S: begin
                        per_stage  <= wdata;
                        pending[0] <= 1'b1;
                    end
                    A_CMP_S: begin
                        cmp_stage  <= wdata;
                        pending[1] <= 1'b1;
                    end
                    A_CTRL:  ctrl <= ctrl_from_word(wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_PER_L: rdata = per_live;
            A_CMP_L: rdata = cmp_live;
            A_PER_S: rdata = per_stage;
            A_CMP_S: rdata = cmp_stage;
            A_CTRL:  rdata = CNT_W'(ctrl_to_word(ctrl));
            default: rdata = '0;
        endcase
    end

    // R8
    stage_per_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && pending[0] && !(wr && addr == A_PER_L)) |=> (per_live == $past(per_stage)));

    // R8
    stage_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_CMP_S) |=> pending[1]);

endmodule

// File: rtl/shadow_pwm_counter.sv
module shadow_pwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sync_clr,
    input  logic [CNT_W-1:0] per_live,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic at_end;
    assign at_end = (count >= per_live);
    assign wrap   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (sync_clr) begin
            count <= '0;
        end else if (run) begin
            count <= at_end ? '0 : count + 1'b1;
        end
    end

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count >= per_live) |=> (count == '0));

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !sync_clr) |=> $stable(count));

    // R9
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sync_clr |=> (count == '0));

endmodule

// File: rtl/shadow_pwm_outgen.sv
module shadow_pwm_outgen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inv,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] per_live,
    input  logic [CNT_W-1:0] cmp_live,
    output logic             pwm_q
);

    logic active;

    always_comb begin
        if (cmp_live == '0)
            active = 1'b0;
        else if (cmp_live >= per_live)
            active = 1'b1;
        else
            active = (count < cmp_live);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwm_q <= 1'b0;
        else
            pwm_q <= en ? (active ^ inv) : 1'b0;
    end

    // R6
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_q);

endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import shadow_pwm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              sync_evt,
    output logic [1:0]        shadow_pending,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_live;
    logic [CNT_W-1:0] cmp_live;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             sync_clr;

    assign sync_clr = sync_evt && (ctrl.sync_sel != SYNC_BLOCKED);

    shadow_pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .wrap     (wrap),
        .per_live (per_live),
        .cmp_live (cmp_live),
        .ctrl     (ctrl),
        .pending  (shadow_pending)
    );

    shadow_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .sync_clr (sync_clr),
        .per_live (per_live),
        .count    (count),
        .wrap     (wrap)
    );

    shadow_pwm_outgen #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl.en),
        .inv      (ctrl.inv),
        .count    (count),
        .per_live (per_live),
        .cmp_live (cmp_live),
        .pwm_q    (pwm_out)
    );

    // R9
    sync_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sync_sel == SYNC_BLOCKED) |-> !sync_clr);

endmodule

// File: tb/shadow_pwm_test.sv
module shadow_pwm_test;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 6;

    // control words: run=0x10, sync blocked=0xC0, enable=0x200, invert=0x400
    localparam logic [31:0] CTL_NORM = 32'h02D0;
    localparam logic [31:0] CTL_INV  = 32'h06D0;

    // {period, compare, invert, expected high clocks per period}
    typedef struct packed {
        logic [7:0] per;
        logic [7:0] cmp;
        logic [7:0] inv;
        logic [7:0] high;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd9,  8'd3, 8'd0, 8'd3,  8'd4},
        '{8'd9,  8'd3, 8'd1, 8'd7,  8'd5},
        '{8'd15, 8'd1, 8'd0, 8'd1,  8'd4},
        '{8'd15, 8'd6, 8'd1, 8'd10, 8'd5},
        '{8'd4,  8'd0, 8'd0, 8'd0,  8'd7},
        '{8'd4,  8'd0, 8'd1, 8'd5,  8'd7},
        '{8'd4,  8'd4, 8'd0, 8'd5,  8'd7},
        '{8'd4,  8'd7, 8'd1, 8'd0,  8'd7}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic              sync_evt = 1'b0;
    logic [1:0]        shadow_pending;
    logic              pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shadow_pwm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk            (clk),
        .rst            (rst),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .sync_evt       (sync_evt),
        .shadow_pending (shadow_pending),
        .pwm_out        (pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a[ADDR_W-1:0];
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        int hi;
        int rises;
        logic prev;

        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(8'h08, r); check("R1 per_live", r, 0);
        rd(8'h0C, r); check("R1 cmp_live", r, 0);
        rd(8'h2A, r); check("R1 ctrl", r, 0);
        check("R1 pending", {30'd0, shadow_pending}, 0);
        check("R1 pwm_out", {31'd0, pwm_out}, 0);

        // R10: control register keeps only its defined bits
        wr(8'h2A, 32'hFFFF_FFFF);
        rd(8'h2A, r); check("R10 ctrl bits", r, 32'h06D0);
        wr(8'h2A, 32'h0);

        // R2: live registers take a write on the next clock
        wr(8'h08, 32'hA5A5_0009);
        rd(8'h08, r); check("R2 per_live", r, 32'hA5A5_0009);
        wr(8'h0C, 32'h0000_0003);
        rd(8'h0C, r); check("R2 cmp_live", r, 3);

        // R10: unmapped write changes nothing
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h08, r); check("R10 unmapped per", r, 32'hA5A5_0009);
        rd(8'h0C, r); check("R10 unmapped cmp", r, 3);
        rd(8'h2A, r); check("R10 unmapped ctrl", r, 0);
        rd(8'h20, r); check("R10 unmapped read", r, 0);

        // Vector table: R4, R5, R7
        foreach (VECS[k]) begin
            wr(8'h2A, 32'h0);
            wr(8'h08, {24'd0, VECS[k].per});
            wr(8'h0C, {24'd0, VECS[k].cmp});
            wr(8'h2A, VECS[k].inv[0] ? CTL_INV : CTL_NORM);
            idle(2 * (VECS[k].per + 1) + 3);
            count_high(VECS[k].per + 1, hi);
            check($sformatf("R%0d vec%0d high", VECS[k].req, k), hi, {24'd0, VECS[k].high});
        end

        // R3: period length P+1 -> exactly 3 rising edges in 3 periods
        wr(8'h2A, 32'h0);
        wr(8'h08, 32'd9);
        wr(8'h0C, 32'd3);
        wr(8'h2A, CTL_NORM);
        idle(25);
        prev = pwm_out;
        rises = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
        check("R3 rises in 30 clocks", rises, 3);

        // R3: stopped counter freezes the output
        wr(8'h2A, 32'h02C0);
        idle(2);
        prev = pwm_out;
        rises = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (pwm_out !== prev) rises++;
        end
        check("R3 stopped no toggles", rises, 0);

        // R6: enable clear forces low even with constant-active compare
        wr(8'h0C, 32'd20);
        wr(8'h2A, 32'h04D0);
        idle(3);
        count_high(20, hi);
        check("R6 disabled low", hi, 0);

        // R8: staging writes while stopped stay pending
        wr(8'h0C, 32'd3);
        wr(8'h2A, 32'h02C0);
        wr(8'h10, 32'd5);
        check("R8 pending period only", {30'd0, shadow_pending}, 2'b01);
        wr(8'h14, 32'd2);
        check("R8 pending both", {30'd0, shadow_pending}, 2'b11);
        idle(15);
        rd(8'h08, r); check("R8 per_live unchanged", r, 9);
        rd(8'h0C, r); check("R8 cmp_live unchanged", r, 3);
        wr(8'h2A, CTL_NORM);
        idle(15);
        check("R8 pending cleared", {30'd0, shadow_pending}, 0);
        rd(8'h08, r); check("R8 per_live updated", r, 5);
        rd(8'h0C, r); check("R8 cmp_live updated", r, 2);
        idle(6);
        count_high(6, hi);
        check("R8 new waveform high", hi, 2);

        // R9: sync pulses clear the counter when allowed
        wr(8'h2A, 32'h0);
        wr(8'h08, 32'd9);
        wr(8'h0C, 32'd5);
        wr(8'h2A, 32'h0210);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i >= 10 && pwm_out) hi++;
            sync_evt = (i % 3 == 0);
        end
        sync_evt = 1'b0;
        check("R9 sync enabled high", hi, 30);

        // R9: sync pulses ignored when field is 11
        wr(8'h2A, CTL_NORM);
        hi = 0;
        for (int i = 0; i < 35; i++) begin
            @(negedge clk);
            if (i >= 25 && pwm_out) hi++;
            sync_evt = (i % 3 == 0);
        end
        sync_evt = 1'b0;
        check("R9 sync blocked high", hi, 5);

        // R1: reset mid-run returns to idle
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 reset pwm", {31'd0, pwm_out}, 0);
        rd(8'h08, r); check("R1 reset per", r, 0);

        done = 1'b1;
        finish_run();
    end

endmodule